// File: doc/BRIEF.md
# Data-Strobe Serial Link Transmitter

This block is the sending side of a two-wire serial port. A parallel client hands it data bytes and end-of-packet markers through a valid/ready handshake, and a separate strobe input requests a time code. The block turns each of these into a framed character and shifts it out on a data line and a strobe line. Exactly one of the two lines changes for each bit, so a receiver can recover the bit clock as the XOR of the two lines. Every character starts with a parity bit that covers the previous character, which lets the far end detect a corrupted bit.

When the client has nothing to send, the block keeps the line active with a NULL pattern (an escape character followed by a flow-control code). A pending time code goes out at the next character boundary, ahead of queued data. The bit period is a programmable number of transmit-clock cycles. After reset the period is fixed at four cycles (10 Mb/s from a 40 MHz transmit clock) until a new rate is written. A new rate only takes effect where one character ends and the next begins.

Top module: `ds_link_tx`

## Requirements
- R1: While reset is active both lines are low. After reset, and until the first rate write, every bit lasts 4 clock cycles, whatever value is on `rate_val`.
- R2: A pulse on `rate_wr` stores `rate_val`. The first character that begins on a later clock edge uses bits of `rate_val`+1 cycles each. The character already on the line keeps its own period.
- R3: On each bit exactly one of `d_out` and `s_out` changes. Neither line changes inside a bit period.
- R4: A data character is 10 bits sent in this order: parity, a flag of 0, then the byte from bit 0 up to bit 7.
- R5: A control character is 4 bits: parity, a flag of 1, then code bit 0 and code bit 1. The codes are FCT=0, EOP=1 and ESC=3.
- R6: The parity bit is chosen so that the previous character's data or code bits, plus the current character's parity and flag bits, hold an odd number of ones. Before the first character, the previous bits count as zero ones.
- R7: With `tx_valid` low and no time code pending, the line carries back-to-back NULLs (ESC, then FCT).
- R8: A `tc_strobe` pulse captures `tc_value`. The value is sent as ESC followed by a data character holding `tc_value`. It starts at the next free character boundary, and `tx_ready` stays low until it has started.
- R9: A character is accepted in a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only in the cycle in which the next character is chosen. With `tx_eop` high, an EOP control character is sent and `tx_data` is ignored.
- R10: The two characters of a NULL or a time code are never split. An ESC is always followed directly by FCT or by a data character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_wr | input | 1 | Store `rate_val` as the pending bit period |
| rate_val | input | 6 | Bit period minus one, in clock cycles |
| tx_valid | input | 1 | Client offers a character |
| tx_eop | input | 1 | Offered character is an end-of-packet marker |
| tx_data | input | 8 | Offered data byte |
| tx_ready | output | 1 | Offered character is taken this cycle |
| tc_strobe | input | 1 | Request a time code |
| tc_value | input | 8 | Time code value |
| d_out | output | 1 | Serial data line |
| s_out | output | 1 | Serial strobe line |

## Verification
A time-code request can arrive in the same cycle in which the encoder picks its next character and accepts a data byte. The bench keeps `tx_valid` asserted with a stream of bytes and fires `tc_strobe` partway through, so the request lands close to a character boundary. The bench decodes the line by watching which wire toggles. It then requires that at most two data characters (the one on the line and the one accepted in that same cycle) appear after the request and before the time code, and that no other character comes between the time code's ESC and its value. A rate write is likewise made in the middle of a character. The measured bit length must switch at the next character boundary and not before.

// File: rtl/ds_link_tx.sv
module ds_link_tx #(
  parameter int RATE_W  = 6,
  parameter int DEF_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              tx_valid,
  input  logic              tx_eop,
  input  logic [7:0]        tx_data,
  output logic              tx_ready,
  input  logic              tc_strobe,
  input  logic [7:0]        tc_value,
  output logic              d_out,
  output logic              s_out
);
  localparam logic [RATE_W-1:0] DEF_PER = RATE_W'(DEF_DIV - 1);
  localparam logic [1:0] C_FCT = 2'd0, C_EOP = 2'd1, C_ESC = 2'd3;
  localparam logic [1:0] F_NONE = 2'd0, F_FCT = 2'd1, F_TCD = 2'd2;

  logic [RATE_W-1:0] per, per_nxt, tmr;
  logic [3:0] nb;
  logic [8:0] sh;
  logic       prevx, tc_pend;
  logic [7:0] tc_buf;
  logic [1:0] follow;

  logic       tick, bound, is_ctl, par, bit_new;
  logic [1:0] code, nxt_follow;
  logic [7:0] dat;
  logic [9:0] frame;

  assign tick  = (tmr == per);
  assign bound = tick && (nb == 4'd0);
  assign tx_ready = bound && (follow == F_NONE) && !tc_pend;

  always_comb begin
    is_ctl = 1'b1;
    code = C_ESC;
    dat = 8'h00;
    nxt_follow = F_NONE;
    if (follow == F_FCT) begin
      code = C_FCT;
    end else if (follow == F_TCD) begin
      is_ctl = 1'b0;
      dat = tc_buf;
    end else if (tc_pend) begin
      nxt_follow = F_TCD;
    end else if (tx_valid) begin
      if (tx_eop) code = C_EOP;
      else begin
        is_ctl = 1'b0;
        dat = tx_data;
      end
    end else begin
      nxt_follow = F_FCT;
    end
  end

  assign par = ~(prevx ^ is_ctl);
  assign frame = is_ctl ? {6'b0, code[1], code[0], 1'b1, par} : {dat, 1'b0, par};
  assign bit_new = bound ? frame[0] : sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per <= DEF_PER;
      per_nxt <= DEF_PER;
      tmr <= DEF_PER;
      nb <= 4'd0;
      sh <= '0;
      prevx <= 1'b0;
      tc_pend <= 1'b0;
      tc_buf <= 8'h00;
      follow <= F_NONE;
      d_out <= 1'b0;
      s_out <= 1'b0;
    end else begin
      if (rate_wr) per_nxt <= rate_val;
      if (tc_strobe) begin
        tc_pend <= 1'b1;
        tc_buf <= tc_value;
      end else if (bound && follow == F_NONE) begin
        tc_pend <= 1'b0;
      end
      if (tick) begin
        tmr <= '0;
        d_out <= bit_new;
        s_out <= (bit_new == d_out) ? ~s_out : s_out;
        if (bound) begin
          per <= per_nxt;
          sh <= frame[9:1];
          nb <= is_ctl ? 4'd3 : 4'd9;
          prevx <= is_ctl ? ^code : ^dat;
          follow <= nxt_follow;
        end else begin
          sh <= {1'b0, sh[8:1]};
          nb <= nb - 4'd1;
        end
      end else begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  // R3
  one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((d_out != $past(d_out)) && (s_out != $past(s_out))));

  // R3
  steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr != '0) |-> ($stable(d_out) && $stable(s_out)));

  // R9
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (nb == ($past(tx_eop) ? 4'd3 : 4'd9)));

  // R2
  rate_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per != $past(per)) |-> ($past(nb) == 4'd0));
endmodule

// File: tb/sim_ds_link_tx.sv
module sim_ds_link_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rate_wr = 1'b0, tx_valid = 1'b0, tx_eop = 1'b0, tc_strobe = 1'b0;
  logic [5:0] rate_val = 6'd20;
  logic [7:0] tx_data = 8'h00, tc_value = 8'h00;
  logic tx_ready, d_out, s_out;

  always #4 clk = ~clk;

  ds_link_tx u0 (.clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_val(rate_val),
    .tx_valid(tx_valid), .tx_eop(tx_eop), .tx_data(tx_data), .tx_ready(tx_ready),
    .tc_strobe(tc_strobe), .tc_value(tc_value), .d_out(d_out), .s_out(s_out));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic [8:0] exp_q[$];
  logic [7:0] tc_q[$];
  bit mon_on = 0, have_bit = 0, esc = 0, prevx = 0, wrote = 0, stg_v = 0;
  logic pd = 0, ps = 0;
  int elapsed = 0, bit_per = 0, char_per = 0, pend = 4, stg = 0;
  int nbits = 0, want = 10, nulls = 0, ndata = 0, ntc = 0, dbt = 0;
  logic bits [0:9];

  task automatic decode();
    logic p, f;
    logic [1:0] c;
    logic [7:0] v;
    logic [8:0] e;
    p = bits[0]; f = bits[1];
    chk((p ^ f ^ prevx) == 1'b1, "R6 parity", int'(p), int'(~(f ^ prevx)));
    if (f) begin
      c = {bits[3], bits[2]};
      prevx = c[0] ^ c[1];
      if (c == 2'd3) begin
        chk(!esc, "R10 esc after esc", 1, 0);
        esc = 1;
      end else if (c == 2'd0) begin
        chk(esc, "R10 lone fct", 0, 1);
        if (esc) nulls++;
        esc = 0;
      end else if (c == 2'd1) begin
        chk(!esc, "R10 esc before eop", 1, 0);
        esc = 0;
        chk(exp_q.size() > 0, "R9 unexpected eop", 0, 1);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(e[8], "R9 eop expected data", int'(e), 256);
        end
      end else begin
        chk(0, "R5 bad code", int'(c), 0);
      end
    end else begin
      for (int i = 0; i < 8; i++) v[i] = bits[i + 2];
      prevx = ^v;
      if (esc) begin
        esc = 0;
        ntc++;
        chk(tc_q.size() > 0, "R8 unexpected time code", int'(v), 0);
        if (tc_q.size() > 0) begin
          e = {1'b0, tc_q.pop_front()};
          chk(v == e[7:0], "R8 time code value", int'(v), int'(e[7:0]));
        end
        chk(dbt <= 2, "R8 data overtook time code", dbt, 2);
      end else begin
        ndata++;
        dbt++;
        chk(exp_q.size() > 0, "R4 unexpected data", int'(v), 0);
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(e == {1'b0, v}, "R4 data value", int'(v), int'(e));
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(d_out == 1'b0 && s_out == 1'b0, "R1 reset lines", int'({d_out, s_out}), 0);
    end else if (mon_on) begin
      bit dch, sch;
      elapsed++;
      dch = (d_out != pd);
      sch = (s_out != ps);
      if (dch || sch) begin
        chk(!(dch && sch), "R3 both lines moved", 2, 1);
        if (have_bit) chk(elapsed == bit_per, wrote ? "R2 bit period" : "R1 bit period", elapsed, bit_per);
        elapsed = 0;
        have_bit = 1;
        if (nbits == 0) char_per = pend;
        bit_per = char_per;
        bits[nbits] = d_out;
        nbits++;
        if (nbits == 2) want = d_out ? 4 : 10;
        if (nbits >= 2 && nbits == want) begin
          decode();
          nbits = 0;
        end
      end else if (have_bit) begin
        chk(elapsed < bit_per, "R3 line stalled", elapsed, bit_per);
      end
      pd = d_out;
      ps = s_out;
      if (stg_v) pend = stg;
      stg_v = rate_wr;
      stg = int'(rate_val) + 1;
      if (tx_valid && tx_ready) exp_q.push_back({tx_eop, tx_eop ? 8'h00 : tx_data});
      if (tc_strobe) begin
        tc_q.push_back(tc_value);
        dbt = 0;
      end
    end
  end

  task automatic send(input logic [7:0] b, input bit eop);
    @(posedge clk); #2;
    tx_valid = 1; tx_data = b; tx_eop = eop;
    forever begin
      @(negedge clk);
      if (tx_ready) break;
    end
    @(posedge clk); #2;
    tx_valid = 0; tx_eop = 0;
  endtask

  task automatic set_rate(input logic [5:0] r);
    @(posedge clk); #2;
    rate_wr = 1; rate_val = r; wrote = 1;
    @(posedge clk); #2;
    rate_wr = 0; rate_val = 6'd33;
  endtask

  task automatic time_code(input logic [7:0] v);
    @(posedge clk); #2;
    tc_strobe = 1; tc_value = v;
    @(posedge clk); #2;
    tc_strobe = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && tc_q.size() == 0 && !esc && nbits == 0) break;
    end
    chk(exp_q.size() == 0, "R9 characters lost", exp_q.size(), 0);
    chk(tc_q.size() == 0, "R8 time codes lost", tc_q.size(), 0);
  endtask

  task automatic run();
    int n0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1; mon_on = 1;
    repeat (400) @(posedge clk);
    chk(nulls >= 10, "R7 idle nulls", nulls, 10);
    chk(ndata == 0, "R7 no data while idle", ndata, 0);
    send(8'h00, 0); send(8'hFF, 0); send(8'hA5, 0); send(8'h5A, 0);
    send(8'hFF, 1);
    send(8'h01, 0); send(8'h80, 0);
    drain();
    set_rate(6'd9);
    send(8'h3C, 0); send(8'hC3, 0);
    fork
      send(8'h77, 0);
      begin repeat (17) @(posedge clk); set_rate(6'd0); end
    join
    send(8'h12, 0); send(8'h00, 1);
    drain();
    fork
      begin for (int i = 0; i < 8; i++) send(8'(i * 37 + 5), 0); end
      begin repeat (35) @(posedge clk); time_code(8'h9B); end
    join
    drain();
    chk(ntc == 1, "R8 time code count", ntc, 1);
    set_rate(6'd2);
    time_code(8'h40);
    drain();
    n0 = nulls;
    repeat (200) @(posedge clk);
    chk(nulls > n0, "R7 nulls resume", nulls, n0 + 1);
    set_rate(6'd63);
    send(8'hE7, 0); send(8'h00, 1);
    drain();
    chk(ntc == 2, "R8 second time code", ntc, 2);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule